// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the memory-mapped register file that stands between a system bus and a SHA-224/SHA-256 compression core. Software writes a 512-bit message block as sixteen 32-bit words, picks the digest width with a mode bit, and starts the core by writing a command register. The command bits become one-cycle pulses toward the core. Software then reads status and the eight digest words straight from the core's outputs. The core is not part of this block. It connects through plain control and status pins.

The interrupt unit latches edges. A rising edge on the core's digest-valid or ready output sets a sticky raw flag, which stays set until software writes a one to the matching clear bit. A mask register gates the raw flags into a masked view, and the single interrupt line is the OR of that masked view. Flag bit 0 tracks digest valid and flag bit 1 tracks ready.

The bus side is a request/response interface. A request is `req_valid` with `req_write`, a byte address and write data. The block has no back-pressure: it takes one request on every cycle in which `req_valid` is high. A read returns `rsp_valid` with `rsp_rdata` on the cycle after it is accepted. The requester must take that response, because there is no stall. Address bits 1:0 are ignored.

Top module: `hash_regfile`

## Requirements
- R1: After reset, every stored register (message words, mode, mask, raw flags) is zero, `core_init`, `core_next`, `core_mode` and `irq` are low, and `rsp_valid` is low.
- R2: The message word at offset 0x0008 + 4*k (k = 0..15) holds `core_block[32k+31:32k]`, so 0x0008 is bits 31:0. It is written by a bus write and reads back the value last written.
- R3: A write to CTRL (0x0004) makes `core_init` high for exactly the next cycle if data bit 0 is 1, and makes `core_next` high for exactly the next cycle if data bit 1 is 1. It stores data bit 2 as `core_mode` (0 = SHA-224, 1 = SHA-256), which holds until the next CTRL write. A read of CTRL returns the mode in bit 2 and zero elsewhere.
- R4: STATUS (0x0000) reads `core_digest_valid` in bit 0 and `core_ready` in bit 1, with zero elsewhere. Writes to it have no effect.
- R5: The digest word at offset 0x0048 + 4*k (k = 0..7) reads `core_digest[32k+31:32k]`. Writes there have no effect.
- R6: The raw flag register RIS (0xFF08) sets bit 0 on a rising edge of `core_digest_valid` and bit 1 on a rising edge of `core_ready`. A set bit stays set while its source stays high or falls. Writes to RIS have no effect.
- R7: Writing a 1 to bit n of IC (0xFF0C) clears RIS bit n on that clock edge. If a rising edge of the source arrives on the same edge, the bit ends up set. IC reads as zero.
- R8: IM (0xFF00) is a readable 2-bit mask. MIS (0xFF04) reads RIS AND IM, and writes to MIS have no effect.
- R9: `irq` is high exactly when some bit of RIS AND IM is 1.
- R10: A read of any other offset returns zero. A write to any other offset changes no register.
- R11: Every request is accepted in the cycle it is presented. A read returns `rsp_valid` high with its data in the next cycle, and a write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| core_init | output | 1 | One-cycle start-new-message pulse to the core |
| core_next | output | 1 | One-cycle continue-message pulse to the core |
| core_mode | output | 1 | Digest width select: 0 = SHA-224, 1 = SHA-256 |
| core_block | output | 512 | Message block to the core |
| core_ready | input | 1 | Core is idle and ready |
| core_digest_valid | input | 1 | Core digest output is valid |
| core_digest | input | 256 | Core digest output |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the interrupt flag corners. A flag source that stays high must not set its flag again after a clear, so a level-sensitive design would show up as `irq` coming back at once. A clear that meets a new edge on the same cycle must leave the flag set, and a design that lets the clear win would lose that event. The bench also checks that the command bits fall back after a single cycle, which catches a stuck or two-cycle pulse. Random traffic over message, digest and unmapped offsets exposes wrong word ordering, writes that land in read-only or unmapped space, and nonzero reads from holes in the map.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int DIG_WORDS = 8;
  localparam int FLAG_W    = 2;
  localparam int IDX_W     = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_STATUS = IDX_W'(16'h0000 >> 2);
  localparam logic [IDX_W-1:0] IDX_CTRL   = IDX_W'(16'h0004 >> 2);
  localparam logic [IDX_W-1:0] IDX_MSG0   = IDX_W'(16'h0008 >> 2);
  localparam logic [IDX_W-1:0] IDX_DIG0   = IDX_W'(16'h0048 >> 2);
  localparam logic [IDX_W-1:0] IDX_IM     = IDX_W'(16'hFF00 >> 2);
  localparam logic [IDX_W-1:0] IDX_MIS    = IDX_W'(16'hFF04 >> 2);
  localparam logic [IDX_W-1:0] IDX_RIS    = IDX_W'(16'hFF08 >> 2);
  localparam logic [IDX_W-1:0] IDX_IC     = IDX_W'(16'hFF0C >> 2);

  typedef enum logic [1:0] {FLAG_VALID = 2'd0, FLAG_READY = 2'd1} flag_e;
endpackage

// File: rtl/hr_msg_store.sv
module hr_msg_store #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  output logic [WORDS*DW-1:0] block
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                word_q <= '0;
      else if (wr_en && wr_idx == IW'(g))        word_q <= wr_data;
    end
    assign block[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/hr_cmd_gen.sv
module hr_cmd_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [2:0] ctrl_data,
  output logic       init_pulse,
  output logic       next_pulse,
  output logic       mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_pulse <= 1'b0;
      next_pulse <= 1'b0;
      mode       <= 1'b0;
    end else begin
      init_pulse <= ctrl_we & ctrl_data[0];
      next_pulse <= ctrl_we & ctrl_data[1];
      if (ctrl_we) mode <= ctrl_data[2];
    end
  end
endmodule

// File: rtl/hr_irq_unit.sv
module hr_irq_unit #(
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] src,
  input  logic          im_we,
  input  logic          ic_we,
  input  logic [FW-1:0] wr_bits,
  output logic [FW-1:0] im,
  output logic [FW-1:0] ris,
  output logic [FW-1:0] mis,
  output logic          irq
);
  logic [FW-1:0] src_q;
  logic [FW-1:0] rise;
  logic [FW-1:0] clr;

  assign rise = src & ~src_q;
  assign clr  = ic_we ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      ris   <= '0;
      im    <= '0;
    end else begin
      src_q <= src;
      ris   <= (ris & ~clr) | rise;   // a new edge beats a clear
      if (im_we) im <= wr_bits;
    end
  end

  assign mis = ris & im;
  assign irq = |mis;
endmodule

// File: rtl/hr_read_mux.sv
module hr_read_mux
  import hr_pkg::*;
(
  input  logic [IDX_W-1:0]            idx,
  input  logic [MSG_WORDS*DATA_W-1:0] block,
  input  logic [DIG_WORDS*DATA_W-1:0] digest,
  input  logic                        st_valid,
  input  logic                        st_ready,
  input  logic                        mode,
  input  logic [FLAG_W-1:0]           im,
  input  logic [FLAG_W-1:0]           ris,
  input  logic [FLAG_W-1:0]           mis,
  output logic [DATA_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_STATUS: rdata = DATA_W'({st_ready, st_valid});
      IDX_CTRL:   rdata = DATA_W'({mode, 2'b00});
      IDX_IM:     rdata = DATA_W'(im);
      IDX_MIS:    rdata = DATA_W'(mis);
      IDX_RIS:    rdata = DATA_W'(ris);
      default: begin
        for (int i = 0; i < MSG_WORDS; i++)
          if (idx == IDX_MSG0 + IDX_W'(i)) rdata = block[i*DATA_W +: DATA_W];
        for (int i = 0; i < DIG_WORDS; i++)
          if (idx == IDX_DIG0 + IDX_W'(i)) rdata = digest[i*DATA_W +: DATA_W];
      end
    endcase
  end
endmodule

// File: rtl/hash_regfile.sv
module hash_regfile
  import hr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic                        core_init,
  output logic                        core_next,
  output logic                        core_mode,
  output logic [MSG_WORDS*DATA_W-1:0] core_block,
  input  logic                        core_ready,
  input  logic                        core_digest_valid,
  input  logic [DIG_WORDS*DATA_W-1:0] core_digest,
  output logic                        irq
);
  localparam int MIW = $clog2(MSG_WORDS);

  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic              msg_we;
  logic [IDX_W-1:0]  msg_off;
  logic [FLAG_W-1:0] im, ris, mis;
  logic [DATA_W-1:0] rdata_c;

  assign idx     = req_addr[ADDR_W-1:2];
  assign wr      = req_valid &  req_write;
  assign rd      = req_valid & ~req_write;
  assign msg_off = idx - IDX_MSG0;
  assign msg_we  = wr && (idx >= IDX_MSG0) && (msg_off < IDX_W'(MSG_WORDS));

  hr_msg_store #(.WORDS(MSG_WORDS), .DW(DATA_W)) u_msg (
    .clk, .rst_n,
    .wr_en   (msg_we),
    .wr_idx  (msg_off[MIW-1:0]),
    .wr_data (req_wdata),
    .block   (core_block)
  );

  hr_cmd_gen u_cmd (
    .clk, .rst_n,
    .ctrl_we    (wr && idx == IDX_CTRL),
    .ctrl_data  (req_wdata[2:0]),
    .init_pulse (core_init),
    .next_pulse (core_next),
    .mode       (core_mode)
  );

  hr_irq_unit #(.FW(FLAG_W)) u_irq (
    .clk, .rst_n,
    .src     ({core_ready, core_digest_valid}),
    .im_we   (wr && idx == IDX_IM),
    .ic_we   (wr && idx == IDX_IC),
    .wr_bits (req_wdata[FLAG_W-1:0]),
    .im, .ris, .mis, .irq
  );

  hr_read_mux u_rmux (
    .idx, .block(core_block), .digest(core_digest),
    .st_valid (core_digest_valid),
    .st_ready (core_ready),
    .mode     (core_mode),
    .im, .ris, .mis,
    .rdata    (rdata_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_c;
    end
  end
endmodule

// File: rtl/hash_regfile_chk.sv
module hash_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        core_init,
  input logic        core_next,
  input logic        core_mode,
  input logic        core_ready,
  input logic        core_digest_valid,
  input logic [1:0]  ris,
  input logic [1:0]  im,
  input logic        irq
);
  logic ctrl_wr, ic_wr;
  assign ctrl_wr = req_valid && req_write && req_addr[15:2] == 14'h0001;
  assign ic_wr   = req_valid && req_write && req_addr[15:2] == 14'h3FC3;

  // R3: pulses only follow a CTRL write with the bit set
  a_r3_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && req_wdata[0]) |=> !core_init);
  a_r3_next_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && req_wdata[1]) |=> !core_next);
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(core_mode));
  // R6: a rising source sets its flag
  a_r6_valid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_digest_valid) |=> ris[0]);
  a_r6_ready_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ready) |=> ris[1]);
  // R7: a set flag only drops through a clear write
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ris[0] && !(ic_wr && req_wdata[0])) |=> ris[0]);
  // R9: a zero mask keeps the line low
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (im == 2'b00) |-> !irq);
  // R11: read response timing
  a_r11_rd_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind hash_regfile hash_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .core_init(core_init), .core_next(core_next), .core_mode(core_mode),
  .core_ready(core_ready), .core_digest_valid(core_digest_valid),
  .ris(ris), .im(im), .irq(irq)
);

// File: tb/hash_regfile_bench.sv
`timescale 1ns/1ps
module hash_regfile_bench;
  logic         clk = 0, rst_n = 0;
  logic         req_valid = 0, req_write = 0;
  logic [15:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         core_init, core_next, core_mode, irq;
  logic [511:0] core_block;
  logic         core_ready = 0, core_digest_valid = 0;
  logic [255:0] core_digest = '0;

  int nvec = 0, nbad = 0;
  logic [31:0] shadow [16];

  always #5 clk = ~clk;

  hash_regfile u_hash_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [15:0] unmapped(input int k);
    case (k % 4)
      0: return 16'h0068 + 16'(4 * (k % 8));
      1: return 16'h1000;
      2: return 16'hFF10;
      default: return 16'hFEFC;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {28'd0, core_init, core_next, core_mode, irq}, 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 block", 32'(|core_block), 32'd0);
    rd(16'h0000, d); chk("R1 R4 status", d, 32'd0);
    rd(16'hFF00, d); chk("R1 im", d, 32'd0);
    rd(16'hFF08, d); chk("R1 ris", d, 32'd0);

    // R3 command pulses and mode
    wr(16'h0004, 32'h0000_0005);
    chk("R3 init high", 32'(core_init), 32'd1);
    chk("R3 next low", 32'(core_next), 32'd0);
    @(negedge clk);
    chk("R3 init one cycle", 32'(core_init), 32'd0);
    chk("R3 mode held", 32'(core_mode), 32'd1);
    wr(16'h0004, 32'h0000_0002);
    chk("R3 next high", 32'(core_next), 32'd1);
    chk("R3 mode cleared", 32'(core_mode), 32'd0);
    @(negedge clk);
    chk("R3 next one cycle", 32'(core_next), 32'd0);
    wr(16'h0004, 32'h0000_0004);
    rd(16'h0004, d); chk("R3 ctrl read", d, 32'h4);

    // R4 status and write ignored
    core_ready = 1;
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, d); chk("R4 status ready", d, 32'h2);

    // R6 edge sets flag; R8 mask; R9 irq
    rd(16'hFF08, d); chk("R6 ris ready", d, 32'h2);
    rd(16'hFF04, d); chk("R8 mis masked", d, 32'h0);
    chk("R9 irq masked", 32'(irq), 32'd0);
    wr(16'hFF00, 32'h3);
    chk("R9 irq on", 32'(irq), 32'd1);
    rd(16'hFF04, d); chk("R8 mis", d, 32'h2);
    wr(16'hFF04, 32'h0); wr(16'hFF08, 32'h0);
    rd(16'hFF00, d); chk("R8 mis write ignored", d, 32'h3);
    rd(16'hFF08, d); chk("R6 ris write ignored", d, 32'h2);
    // R7 clear; level alone does not re-set
    wr(16'hFF0C, 32'h2);
    chk("R7 irq cleared", 32'(irq), 32'd0);
    repeat (3) @(negedge clk);
    rd(16'hFF08, d); chk("R7 ris stays clear while high", d, 32'h0);
    rd(16'hFF0C, d); chk("R7 ic reads zero", d, 32'h0);
    // R7 same-cycle edge beats clear
    @(negedge clk);
    core_digest_valid = 1;
    req_valid = 1; req_write = 1; req_addr = 16'hFF0C; req_wdata = 32'h1;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd(16'hFF08, d); chk("R7 set wins", d, 32'h1);
    chk("R9 irq valid", 32'(irq), 32'd1);
    core_digest_valid = 0;
    repeat (2) @(negedge clk);
    rd(16'hFF08, d); chk("R6 sticky after fall", d, 32'h1);
    wr(16'hFF0C, 32'h3);
    rd(16'hFF08, d); chk("R7 cleared", d, 32'h0);

    // R5 digest write ignored, R2 word order
    wr(16'h0008, 32'hA5A5_0001); shadow[0] = 32'hA5A5_0001;
    wr(16'h0044, 32'h5A5A_000F); shadow[15] = 32'h5A5A_000F;
    chk("R2 low word pin", core_block[31:0], 32'hA5A5_0001);
    chk("R2 high word pin", core_block[511:480], 32'h5A5A_000F);
    for (int k = 0; k < 8; k++) core_digest[k*32 +: 32] = 32'hD000_0000 + 32'(k);
    wr(16'h0048, 32'hFFFF_FFFF);
    rd(16'h0048, d); chk("R5 digest word0", d, 32'hD000_0000);
    rd(16'h0064, d); chk("R5 digest word7", d, 32'hD000_0007);
    chk("R5 write no msg effect", core_block[31:0], 32'hA5A5_0001);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int r, k;
      logic [31:0] v;
      r = int'($urandom % 6);
      k = int'($urandom % 16);
      v = $urandom;
      case (r)
        0: begin wr(16'h0008 + 16'(4*k), v); shadow[k] = v; end
        1: begin rd(16'h0008 + 16'(4*k), d); chk("R2 msg read", d, shadow[k]);
                 chk("R2 msg pin", core_block[k*32 +: 32], shadow[k]); end
        2: begin rd(16'h0048 + 16'(4*(k%8)), d);
                 chk("R5 digest read", d, core_digest[(k%8)*32 +: 32]); end
        3: wr(unmapped(k), v);
        4: begin rd(unmapped(k), d); chk("R10 unmapped read", d, 32'd0); end
        default: for (int j = 0; j < 8; j++) core_digest[j*32 +: 32] = $urandom;
      endcase
    end
    for (int k = 0; k < 16; k++) begin
      rd(16'h0008 + 16'(4*k), d); chk("R10 msg intact", d, shadow[k]);
    end
    rd(16'hFF00, d); chk("R10 im intact", d, 32'h3);
    chk("R10 mode intact", 32'(core_mode), 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule